// File: doc/BRIEF.md
# Runtime Core Clock Source Selector

This block picks the core clock from four inputs while software keeps running: a slow watchdog oscillator, an internal RC oscillator, the same RC oscillator after a frequency doubler, and an external clock that is either a crystal or a directly driven clock. Software writes a control word with a single strobe. The word holds a source code, a clock-output enable and a low-power bit. A status flag tells software whether a source change is still in flight. The flag goes low when a change begins and comes back high when the change has finished. While the flag is low the block refuses all control writes.

The handover between clocks never produces a glitch. The lane that is running drops its gate on its own falling edge, after a synchronizer. The incoming lane raises its gate only after it has seen every other gate closed and two of its own edges have gone by. The block also drives an optional clock output at half the core clock. That output runs only while it is enabled, the part is not idle, and nothing uses the crystal: not the core, not the real-time clock and not the watchdog timer.

All pins are plain control and status signals. There is no streaming interface, so the block has no back-pressure.

Top module: `cs_clock_switch`

## Requirements
- R1: After reset: `cur_sel` is 1 (internal RC), `switch_done` is 1, `lowpow` is 0, `clkout_oe` is 0 and `clkout` is 0.
- R2: Source codes are 0 = watchdog oscillator, 1 = internal RC, 2 = doubled RC, 3 = external clock. Once a switch completes, `core_clk` runs at the period of the selected source and `cur_sel` shows that code.
- R3: A write accepted with a code different from `cur_sel` drives `switch_done` low on the same `clk_reg` edge that takes the write. The flag returns high only after the new source's gate is open.
- R4: A write presented while `switch_done` is 0 is ignored entirely. This includes a write that is still held on the edge where the flag returns to 1.
- R5: A write whose code equals `cur_sel` updates the other fields and leaves `switch_done` at 1.
- R6: `core_clk` never shows a high or low pulse shorter than the shorter half-period of the two sources involved in a switch.
- R7: While `clkout` is enabled and allowed, it toggles on every rising edge of `core_clk`, so it runs at exactly half the core frequency.
- R8: With the enable bit (`wr_out_en` as last accepted) at 0, `clkout_oe` is 0 and `clkout` stays low.
- R9: `clkout_oe` is 0 and `clkout` stays low whenever the crystal is in use. The crystal is in use when `rtc_on_xtal` is 1, when `wdt_on_xtal` is 1, or when `cur_sel` is 3 and `ext_is_xtal` is 1. With source 3 and `ext_is_xtal` at 0 the output may run.
- R10: While `idle` is 1, `clkout` is held low and the divider keeps its state. When `idle` returns to 0, toggling resumes.
- R11: `lowpow` can be set only in a write that selects code 0 or 1, the slow sources. A write that selects code 2 or 3 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register/control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_wdg | input | 1 | Watchdog oscillator |
| clk_rc | input | 1 | Internal RC oscillator |
| clk_rc2x | input | 1 | Doubled RC oscillator |
| clk_ext | input | 1 | External clock (crystal or direct input) |
| ext_is_xtal | input | 1 | External source is a crystal |
| rtc_on_xtal | input | 1 | Real-time clock runs from the crystal |
| wdt_on_xtal | input | 1 | Watchdog timer runs from the crystal |
| idle | input | 1 | Idle mode: freeze and silence the clock output |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 2 | Requested source code |
| wr_out_en | input | 1 | Clock-output enable bit |
| wr_lowpow | input | 1 | Low-power mode bit |
| core_clk | output | 1 | Selected core clock |
| switch_done | output | 1 | 1 = no switch in progress |
| cur_sel | output | 2 | Currently requested source code |
| lowpow | output | 1 | Low-power mode bit |
| clkout_oe | output | 1 | Pin acts as clock output |
| clkout | output | 1 | Core clock divided by two |

## Verification
Two things can coincide in one `clk_reg` cycle: the status flag returning to 1, and a control write arriving. The bench provokes this by holding a write to another source asserted through the whole busy window. It releases the write only on the falling edge after the flag is seen high, so the last write attempt shares an edge with the flag's rise. The result is correct only if that write was refused: exactly one completion comes out, the source is the first one requested, and the flag stays at 1 afterwards.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  localparam int N_SRC = 4;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_WDG  = 2'd0,
    SRC_RC   = 2'd1,
    SRC_RC2X = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

  function automatic logic is_slow(input logic [SEL_W-1:0] s);
    return (s == SRC_WDG) || (s == SRC_RC);
  endfunction
endpackage

// File: rtl/cs_lane.sv
`timescale 1ns/1ps
module cs_lane #(
  parameter int SYNC   = 2,
  parameter bit ON_RST = 1'b0
) (
  input  logic ck,
  input  logic rst_n,
  input  logic req,
  input  logic others_off,
  output logic gate
);
  logic [SYNC-1:0] sh;

  always_ff @(posedge ck or negedge rst_n) begin
    if (!rst_n) sh <= {SYNC{ON_RST}};
    else        sh <= {sh[SYNC-2:0], req & others_off};
  end

  // gate moves only while this clock is low
  always_ff @(negedge ck or negedge rst_n) begin
    if (!rst_n) gate <= ON_RST;
    else        gate <= sh[SYNC-1];
  end
endmodule

// File: rtl/cs_ctrl.sv
`timescale 1ns/1ps
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int N    = N_SRC,
  parameter int SYNC = 2,
  parameter int RESET_SEL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_out_en,
  input  logic             wr_lowpow,
  input  logic [N-1:0]     gates,
  output logic [SEL_W-1:0] sel_q,
  output logic [N-1:0]     req,
  output logic             done_q,
  output logic             out_en_q,
  output logic             lowpow_q
);
  localparam logic [N-1:0] ONE     = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] RST_HOT = ONE << RESET_SEL;

  logic [SYNC-1:0][N-1:0] sy;
  logic [N-1:0]           seen;
  logic                   take;

  assign req  = ONE << sel_q;
  assign seen = sy[SYNC-1];
  assign take = wr_en && done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= {SYNC{RST_HOT}};
    else        sy <= {sy[SYNC-2:0], gates};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SEL_W'(RESET_SEL);
      done_q   <= 1'b1;
      out_en_q <= 1'b0;
      lowpow_q <= 1'b0;
    end else if (take) begin
      sel_q    <= wr_sel;
      out_en_q <= wr_out_en;
      lowpow_q <= wr_lowpow & is_slow(wr_sel);
      if (wr_sel != sel_q) done_q <= 1'b0;
    end else if (!done_q && seen == req) begin
      done_q <= 1'b1;
    end
  end

  p_busy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && done_q && wr_sel != sel_q) |=> !done_q);
  p_refuse_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q) |=> $stable(sel_q) && $stable(out_en_q) && $stable(lowpow_q));
  p_same_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (!wr_en || wr_sel == sel_q)) |=> done_q);
  p_lowpow_slow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lowpow_q |-> is_slow(sel_q));
endmodule

// File: rtl/cs_clkout.sv
`timescale 1ns/1ps
module cs_clkout (
  input  logic core_clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic xtal_busy,
  input  logic idle,
  output logic oe,
  output logic clkout
);
  logic tog;
  logic run;

  assign oe  = out_en & ~xtal_busy;
  assign run = oe & ~idle;

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n)   tog <= 1'b0;
    else if (run) tog <= ~tog;
  end

  assign clkout = tog & run;

  p_idle_hold_r10: assert property (@(posedge core_clk) disable iff (!rst_n)
    idle |=> $stable(tog));
  p_toggle_r7: assert property (@(posedge core_clk) disable iff (!rst_n)
    run |=> tog != $past(tog));
endmodule

// File: rtl/cs_clock_switch.sv
`timescale 1ns/1ps
module cs_clock_switch
  import cs_pkg::*;
#(
  parameter int SYNC      = 2,
  parameter int RESET_SEL = 1
) (
  input  logic             clk_reg,
  input  logic             rst_n,
  input  logic             clk_wdg,
  input  logic             clk_rc,
  input  logic             clk_rc2x,
  input  logic             clk_ext,
  input  logic             ext_is_xtal,
  input  logic             rtc_on_xtal,
  input  logic             wdt_on_xtal,
  input  logic             idle,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_out_en,
  input  logic             wr_lowpow,
  output logic             core_clk,
  output logic             switch_done,
  output logic [SEL_W-1:0] cur_sel,
  output logic             lowpow,
  output logic             clkout_oe,
  output logic             clkout
);
  localparam int N = N_SRC;

  logic [N-1:0] clks, gates, req;
  logic         out_en, xtal_busy;

  assign clks = {clk_ext, clk_rc2x, clk_rc, clk_wdg};

  cs_ctrl #(.N(N), .SYNC(SYNC), .RESET_SEL(RESET_SEL)) u_ctrl (
    .clk(clk_reg), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_out_en(wr_out_en), .wr_lowpow(wr_lowpow), .gates(gates),
    .sel_q(cur_sel), .req(req), .done_q(switch_done),
    .out_en_q(out_en), .lowpow_q(lowpow)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam logic [N-1:0] ME = {{(N-1){1'b0}}, 1'b1} << i;
    logic others_off;
    assign others_off = ~|(gates & ~ME);
    cs_lane #(.SYNC(SYNC), .ON_RST(i == RESET_SEL)) u_lane (
      .ck(clks[i]), .rst_n(rst_n), .req(req[i]),
      .others_off(others_off), .gate(gates[i])
    );
  end

  assign core_clk  = |(gates & clks);
  assign xtal_busy = rtc_on_xtal | wdt_on_xtal |
                     (ext_is_xtal && cur_sel == SRC_EXT);

  cs_clkout u_out (
    .core_clk(core_clk), .rst_n(rst_n), .out_en(out_en),
    .xtal_busy(xtal_busy), .idle(idle), .oe(clkout_oe), .clkout(clkout)
  );

  p_one_gate_r6: assert property (@(posedge clk_reg) disable iff (!rst_n)
    $onehot0(gates));
  p_done_gate_r3: assert property (@(posedge clk_reg) disable iff (!rst_n)
    $rose(switch_done) |-> (gates & req) != '0);
endmodule

// File: tb/test_cs_clock_switch.sv
`timescale 1ns/1ps
module test_cs_clock_switch;
  logic clk_reg = 0, clk_wdg = 0, clk_rc = 0, clk_rc2x = 0, clk_ext = 0;
  logic rst_n = 0;
  logic ext_is_xtal = 0, rtc_on_xtal = 0, wdt_on_xtal = 0, idle = 0;
  logic wr_en = 0, wr_out_en = 0, wr_lowpow = 0;
  logic [1:0] wr_sel = 0;
  logic core_clk, switch_done, lowpow, clkout_oe, clkout;
  logic [1:0] cur_sel;

  always #2.5 clk_reg  = ~clk_reg;
  always #20  clk_wdg  = ~clk_wdg;
  always #7   clk_rc   = ~clk_rc;
  always #3.5 clk_rc2x = ~clk_rc2x;
  always #5   clk_ext  = ~clk_ext;

  cs_clock_switch i_cs_clock_switch (.*);

  int checks = 0, fails = 0;
  real half_of [4] = '{20.0, 7.0, 3.5, 5.0};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [1:0] sel; real period; } exp_t;
  exp_t q[$];

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge switch_done);
      if (q.size() == 0) begin
        chk(0, "R4", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        realtime t0, t1;
        e = q.pop_front();
        @(posedge core_clk); t0 = $realtime;
        @(posedge core_clk); t1 = $realtime;
        chk(cur_sel == e.sel, "R2", "cur_sel after switch", cur_sel, e.sel);
        chk((t1 - t0) > e.period - 0.01 && (t1 - t0) < e.period + 0.01,
            "R2", "core period ps", int'((t1 - t0) * 1000.0), int'(e.period * 1000.0));
      end
    end
  end

  // glitch monitor
  real min_w = 3.5;
  realtime last_edge = 0;
  bit edge_valid = 0;
  int glitches = 0;
  always @(core_clk) begin
    if (rst_n && edge_valid && ($realtime - last_edge) < min_w - 0.001) glitches++;
    last_edge = $realtime;
    edge_valid = rst_n;
  end

  // clkout counter
  bit cnt_on = 0;
  int co_cnt = 0;
  always @(posedge clkout) if (cnt_on) co_cnt++;

  task automatic count_out(output int n);
    co_cnt = 0;
    @(negedge core_clk); cnt_on = 1;
    repeat (40) @(negedge core_clk);
    cnt_on = 0;
    n = co_cnt;
  endtask

  task automatic wr(input logic [1:0] s, input logic en, input logic lp);
    @(negedge clk_reg);
    wr_en = 1; wr_sel = s; wr_out_en = en; wr_lowpow = lp;
    @(negedge clk_reg);
    wr_en = 0;
  endtask

  task automatic wait_done();
    while (!switch_done) @(negedge clk_reg);
    repeat (30) @(negedge clk_reg);
  endtask

  task automatic sw(input logic [1:0] s, input logic en, input logic lp);
    exp_t e;
    min_w = (half_of[cur_sel] < half_of[s]) ? half_of[cur_sel] : half_of[s];
    e.sel = s; e.period = 2.0 * half_of[s];
    q.push_back(e);
    wr(s, en, lp);
    chk(switch_done == 0, "R3", "flag low after accepted write", switch_done, 0);
    wait_done();
  endtask

  initial begin
    #200000;
    chk(0, "WATCHDOG", "run hung", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (10) @(negedge clk_reg);
    rst_n = 1;
    @(negedge clk_reg);
    chk(cur_sel == 1, "R1", "reset cur_sel", cur_sel, 1);
    chk(switch_done == 1, "R1", "reset switch_done", switch_done, 1);
    chk(lowpow == 0, "R1", "reset lowpow", lowpow, 0);
    chk(clkout_oe == 0 && clkout == 0, "R1", "reset clkout", clkout_oe, 0);

    // R5: same source, no busy period
    wr(2'd1, 0, 0);
    chk(switch_done == 1, "R5", "same-source write keeps flag", switch_done, 1);
    // R11: lowpow allowed on slow source
    wr(2'd1, 0, 1);
    chk(lowpow == 1, "R11", "lowpow set on RC", lowpow, 1);
    repeat (10) @(negedge clk_reg);
    chk(switch_done == 1, "R5", "flag still high", switch_done, 1);

    // switches through every source (R2, R3, R6)
    sw(2'd2, 0, 1);
    chk(lowpow == 0, "R11", "lowpow refused on doubled RC", lowpow, 0);
    sw(2'd3, 0, 0);

    // R4: write held through busy window, released after flag rises
    begin
      exp_t e;
      min_w = 5.0;
      e.sel = 2'd0; e.period = 40.0;
      q.push_back(e);
      wr(2'd0, 0, 0);
      chk(switch_done == 0, "R3", "flag low after accepted write", switch_done, 0);
      wr_en = 1; wr_sel = 2'd3; wr_out_en = 1; wr_lowpow = 1;
      while (!switch_done) @(negedge clk_reg);
      wr_en = 0;
      repeat (40) @(negedge clk_reg);
      chk(cur_sel == 0, "R4", "busy write ignored (sel)", cur_sel, 0);
      chk(switch_done == 1, "R4", "no second switch", switch_done, 1);
      chk(clkout_oe == 0, "R4", "busy write ignored (enable)", clkout_oe, 0);
      chk(lowpow == 0, "R4", "busy write ignored (lowpow)", lowpow, 0);
    end
    sw(2'd1, 0, 0);

    // R7: clkout half of core
    wr(2'd1, 1, 0);
    count_out(n);
    chk(clkout_oe == 1, "R7", "oe on RC", clkout_oe, 1);
    chk(n == 20, "R7", "clkout rises per 40 core edges", n, 20);
    // R8
    wr(2'd1, 0, 0);
    count_out(n);
    chk(n == 0 && clkout_oe == 0, "R8", "disabled clkout rises", n, 0);
    // R9
    wr(2'd1, 1, 0);
    rtc_on_xtal = 1;
    count_out(n);
    chk(clkout_oe == 0 && n == 0, "R9", "rtc on crystal blocks", n, 0);
    rtc_on_xtal = 0; wdt_on_xtal = 1;
    count_out(n);
    chk(clkout_oe == 0 && n == 0, "R9", "wdt on crystal blocks", n, 0);
    wdt_on_xtal = 0;
    sw(2'd3, 1, 0);
    chk(clkout_oe == 1, "R9", "direct external input allows", clkout_oe, 1);
    count_out(n);
    chk(n == 20, "R7", "clkout rises on external", n, 20);
    ext_is_xtal = 1;
    count_out(n);
    chk(clkout_oe == 0 && n == 0, "R9", "core on crystal blocks", n, 0);
    ext_is_xtal = 0;
    // R10
    @(negedge core_clk); idle = 1;
    count_out(n);
    chk(n == 0 && clkout == 0, "R10", "idle silences clkout", n, 0);
    idle = 0;
    count_out(n);
    chk(n == 20, "R10", "toggling resumes after idle", n, 20);

    chk(glitches == 0, "R6", "short core_clk pulses", glitches, 0);
    chk(q.size() == 0, "R2", "pending completions", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule